// File: doc/BRIEF.md
# 3x3 Sliding Window Line Buffer

This block turns a raster-order stream of 8-bit grayscale pixels into a 3x3 neighbourhood for a downstream filter. Images are 96 pixels across and 64 rows deep. Each accepted pixel is pushed into a delay line holding exactly two image rows plus three pixels (195 entries). Nine taps on that line, spaced by the 96-pixel row pitch, form the window. When the input runs without gaps the block delivers one window per clock, so a filter behind it can produce one result per cycle.

A small controller tracks the column and row of the incoming pixel and marks which windows are genuine. A window is flagged only after enough of the current frame has arrived to fill all three window rows, and never when its right column sits in column 0 or 1 of a row, where the three columns would straddle two image rows. Each flagged window carries the row and column of its centre pixel. A frame-start pulse restarts the position tracking; stored pixels are left alone, since they are flushed before any new window can be flagged.

The controller has three states. FILL is the reset state and covers the first two rows of a frame. FILL goes to STREAM when the last pixel of row 1 is accepted. STREAM goes to DONE when the last pixel of row 63 is accepted. DONE waits for a frame-start pulse. A frame-start pulse from any state re-enters FILL at column 0, row 0.

Top module: `sw_window3x3`

## Requirements
- R1: While reset is high, and in the first cycle after it, `win_valid_o` is 0.
- R2: The delay line advances, and a window can be flagged, only on a cycle where `pix_valid_i` is 1; cycles with `pix_valid_i` low change neither taps nor coordinates and flag nothing.
- R3: `win_o` holds tap (r,c) in bits [8*(3*r+c)+7 : 8*(3*r+c)], r=0 top row, c=0 left column; tap (r,c) is the pixel accepted (2-r)*96+(2-c) pixels before the newest one, so tap (2,2) is the newest pixel and tap (1,1) the centre.
- R4: A window is flagged only for a newest pixel with row index 2 or more, so no window appears before 195 pixels of the frame have been accepted.
- R5: No window is flagged when the newest pixel sits in column 0 or column 1.
- R6: With each flagged window, `ctr_row_o` equals the newest pixel's row minus 1 and `ctr_col_o` its column minus 1, so centres span rows 1..62 and columns 1..94.
- R7: Outputs for an accepted pixel appear in the cycle after it is taken; continuous input yields one flagged window per cycle inside the valid region.
- R8: `frame_start_i` restarts position tracking: if `pix_valid_i` is also 1, that pixel is column 0, row 0; if not, the next accepted pixel is. This applies mid-frame as well.
- R9: After the 6144th pixel of a frame, further pixels without a frame-start pulse are ignored: no window is flagged and the taps stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pix_i | input | 8 | Incoming pixel |
| pix_valid_i | input | 1 | Pixel on `pix_i` is taken this cycle |
| frame_start_i | input | 1 | Restart position tracking for a new frame |
| win_o | output | 72 | Nine window taps, layout as in R3 |
| win_valid_o | output | 1 | Current window is a genuine 3x3 neighbourhood |
| ctr_row_o | output | 6 | Row of the window centre |
| ctr_col_o | output | 7 | Column of the window centre |

## Verification
The bench goes after the wrap columns 0 and 1 of every row. A design that mis-sized this test would flag windows mixing the right edge of one row with the left edge of the next, and the tap values would show it. It also checks the exact first window at row 2, column 2, where a delay line one entry short or long would shift every tap by one pixel. It covers a frame-start pulse mid-frame, both alone and with a pixel, where a design counting from the wrong pixel would flag windows too early or give wrong centre coordinates. It also sends pixels after a frame has finished, which a design without the DONE state would shift in, flagging stray windows and changing the taps.

// File: rtl/sw_pkg.sv
package sw_pkg;

    // Frame progress of the incoming pixel stream.
    typedef enum logic [1:0] {
        WS_FILL   = 2'd0,   // first two rows: window not yet complete
        WS_STREAM = 2'd1,   // rows 2..last: windows available
        WS_DONE   = 2'd2    // frame fully received: wait for frame start
    } fill_state_e;

    localparam int unsigned WIN_TAPS = 9;

endpackage

// File: rtl/sw_line_store.sv
module sw_line_store #(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned IMG_W = 96
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 shift_i,
    input  logic [PIX_W-1:0]                     pix_i,
    output logic [sw_pkg::WIN_TAPS*PIX_W-1:0]    taps_o
);

    localparam int unsigned DEPTH = 2 * IMG_W + 3;

    logic [PIX_W-1:0] line_q [DEPTH];

    // Storage is not reset: a new frame flushes it before any window is flagged.
    always_ff @(posedge clk) begin
        if (shift_i) begin
            line_q[0] <= pix_i;
            for (int i = 1; i < DEPTH; i++) begin
                line_q[i] <= line_q[i-1];
            end
        end
    end

    for (genvar wr = 0; wr < 3; wr++) begin : g_row
        for (genvar wc = 0; wc < 3; wc++) begin : g_col
            localparam int unsigned OFS = (2 - wr) * IMG_W + (2 - wc);
            assign taps_o[(wr*3+wc)*PIX_W +: PIX_W] = line_q[OFS];
        end
    end

    // The delay line must hold its contents on idle cycles.
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !shift_i |=> $stable(taps_o));

    // Middle-left tap of the next cycle is the centre tap of this one after a shift.
    assert_tap_pitch_R3: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> taps_o[3*PIX_W +: PIX_W] == $past(taps_o[4*PIX_W +: PIX_W]));

endmodule

// File: rtl/sw_raster_ctrl.sv
module sw_raster_ctrl #(
    parameter int unsigned IMG_W = 96,
    parameter int unsigned IMG_H = 64,
    localparam int unsigned CW   = $clog2(IMG_W),
    localparam int unsigned RW   = $clog2(IMG_H)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_valid_i,
    input  logic          frame_start_i,
    output logic          shift_o,
    output logic          win_valid_o,
    output logic [RW-1:0] ctr_row_o,
    output logic [CW-1:0] ctr_col_o
);

    import sw_pkg::*;

    localparam logic [CW-1:0] COL_LAST = CW'(IMG_W - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(IMG_H - 1);

    fill_state_e   state_q, state_d, eff_state;
    logic [CW-1:0] col_q, col_d, pos_col;
    logic [RW-1:0] row_q, row_d, pos_row;
    logic          shift;
    logic          row_end;

    logic          win_valid_q;
    logic [RW-1:0] ctr_row_q;
    logic [CW-1:0] ctr_col_q;

    // A frame-start pulse overrides the tracked position for this cycle.
    always_comb begin
        eff_state = frame_start_i ? WS_FILL : state_q;
        pos_col   = frame_start_i ? '0 : col_q;
        pos_row   = frame_start_i ? '0 : row_q;
        shift     = pix_valid_i && (eff_state != WS_DONE);
        row_end   = (pos_col == COL_LAST);
    end

    // Next state and next position.
    always_comb begin
        state_d = eff_state;
        col_d   = pos_col;
        row_d   = pos_row;
        if (shift) begin
            if (row_end) begin
                col_d = '0;
                row_d = (pos_row == ROW_LAST) ? '0 : pos_row + RW'(1);
            end else begin
                col_d = pos_col + CW'(1);
            end
        end
        unique case (eff_state)
            WS_FILL: begin
                if (shift && row_end && pos_row == RW'(1))
                    state_d = WS_STREAM;
            end
            WS_STREAM: begin
                if (shift && row_end && pos_row == ROW_LAST)
                    state_d = WS_DONE;
            end
            WS_DONE: begin
                state_d = WS_DONE;
            end
            default: begin
                state_d = WS_FILL;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_FILL;
            col_q   <= '0;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            col_q   <= col_d;
            row_q   <= row_d;
        end
    end

    // Output register: window flag and centre coordinate.
    always_ff @(posedge clk) begin
        if (rst) begin
            win_valid_q <= 1'b0;
            ctr_row_q   <= '0;
            ctr_col_q   <= '0;
        end else begin
            win_valid_q <= shift && (eff_state == WS_STREAM) && (pos_col >= CW'(2));
            if (shift) begin
                ctr_row_q <= pos_row - RW'(1);
                ctr_col_q <= pos_col - CW'(1);
            end
        end
    end

    assign shift_o     = shift;
    assign win_valid_o = win_valid_q;
    assign ctr_row_o   = ctr_row_q;
    assign ctr_col_o   = ctr_col_q;

    // A flagged window always stems from a pixel taken one cycle earlier.
    assert_win_needs_pixel_R2: assert property (@(posedge clk) disable iff (rst)
        win_valid_o |-> $past(pix_valid_i));

    // Centre column never touches the left or right image edge.
    assert_ctr_col_range_R5: assert property (@(posedge clk) disable iff (rst)
        win_valid_o |-> (ctr_col_o >= CW'(1)) && (ctr_col_o <= CW'(IMG_W - 2)));

    // Centre row never touches the top or bottom image edge.
    assert_ctr_row_range_R6: assert property (@(posedge clk) disable iff (rst)
        win_valid_o |-> (ctr_row_o >= RW'(1)) && (ctr_row_o <= RW'(IMG_H - 2)));

    // Windows only once the first two rows are in.
    assert_fill_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_FILL || frame_start_i) |=> !win_valid_o);

    // A finished frame ignores pixels until the next frame start.
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_DONE && !frame_start_i) |=> !win_valid_o);

    // Column position stays inside the image width.
    assert_col_bound_R8: assert property (@(posedge clk) disable iff (rst)
        col_q <= COL_LAST);

endmodule

// File: rtl/sw_window3x3.sv
module sw_window3x3 #(
    parameter int unsigned PIX_W = 8,
    parameter int unsigned IMG_W = 96,
    parameter int unsigned IMG_H = 64,
    localparam int unsigned CW   = $clog2(IMG_W),
    localparam int unsigned RW   = $clog2(IMG_H),
    localparam int unsigned WW   = sw_pkg::WIN_TAPS * PIX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] pix_i,
    input  logic             pix_valid_i,
    input  logic             frame_start_i,
    output logic [WW-1:0]    win_o,
    output logic             win_valid_o,
    output logic [RW-1:0]    ctr_row_o,
    output logic [CW-1:0]    ctr_col_o
);

    logic shift;

    sw_raster_ctrl #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .pix_valid_i   (pix_valid_i),
        .frame_start_i (frame_start_i),
        .shift_o       (shift),
        .win_valid_o   (win_valid_o),
        .ctr_row_o     (ctr_row_o),
        .ctr_col_o     (ctr_col_o)
    );

    sw_line_store #(
        .PIX_W (PIX_W),
        .IMG_W (IMG_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .shift_i (shift),
        .pix_i   (pix_i),
        .taps_o  (win_o)
    );

endmodule

// File: tb/tb_sw_window3x3.sv
`timescale 1ns/1ps
module tb_sw_window3x3;

    localparam int W = 96;
    localparam int H = 64;
    localparam int NPIX = W * H;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pix_i = '0;
    logic        pix_valid_i = 1'b0;
    logic        frame_start_i = 1'b0;
    logic [71:0] win_o;
    logic        win_valid_o;
    logic [5:0]  ctr_row_o;
    logic [6:0]  ctr_col_o;

    always #2.5 clk = ~clk;

    sw_window3x3 dut (
        .clk           (clk),
        .rst           (rst),
        .pix_i         (pix_i),
        .pix_valid_i   (pix_valid_i),
        .frame_start_i (frame_start_i),
        .win_o         (win_o),
        .win_valid_o   (win_valid_o),
        .ctr_row_o     (ctr_row_o),
        .ctr_col_o     (ctr_col_o)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    string phase    = "R1 reset";

    // Behavioural reference: pixel index in frame and stored frame image.
    logic [7:0]  img [NPIX];
    int          n_m    = 0;
    bit          done_m = 0;
    bit          exp_v  = 0;
    logic [71:0] exp_win = '0;
    int          exp_row = 0;
    int          exp_col = 0;

    task automatic check(input bit ok, input string what, input logic [71:0] got, input logic [71:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", phase, what, got, exp);
        end
    endtask

    task automatic model(input bit v, input bit s, input logic [7:0] p);
        int r, c, m;
        if (s) begin
            n_m = 0;
            done_m = 0;
        end
        exp_v = 0;
        if (v && !done_m) begin
            r = n_m / W;
            c = n_m % W;
            img[n_m] = p;
            if (r >= 2 && c >= 2) begin
                exp_v   = 1;
                m       = n_m - W - 1;
                exp_row = r - 1;
                exp_col = c - 1;
                for (int wr = 0; wr < 3; wr++)
                    for (int wc = 0; wc < 3; wc++)
                        exp_win[(wr*3+wc)*8 +: 8] = img[m + (wr-1)*W + (wc-1)];
            end
            n_m++;
            if (n_m == NPIX) done_m = 1;
        end
    endtask

    // One clock: compare outputs of the last edge, then drive the next input.
    task automatic step(input bit v, input bit s, input logic [7:0] p);
        @(negedge clk);
        check(win_valid_o == exp_v, "R4/R5/R7 win_valid", {71'd0, win_valid_o}, {71'd0, exp_v});
        if (exp_v && win_valid_o) begin
            check(win_o == exp_win, "R3 taps", win_o, exp_win);
            check(ctr_row_o == exp_row[5:0] && ctr_col_o == exp_col[6:0], "R6 centre row/col",
                  {58'd0, ctr_row_o, 1'b0, ctr_col_o}, {58'd0, exp_row[5:0], 1'b0, exp_col[6:0]});
        end
        model(v, s, p);
        pix_valid_i   = v;
        frame_start_i = s;
        pix_i         = p;
    endtask

    task automatic run_pixels(input int npix, input int gapmax, input bit sof_first);
        for (int k = 0; k < npix; k++) begin
            if (gapmax > 0) repeat ($urandom_range(0, gapmax)) step(0, 0, 8'($urandom));
            step(1, (k == 0) && sof_first, 8'($urandom));
        end
    endtask

    initial begin
        logic [71:0] held;
        // R1: reset state
        repeat (4) @(negedge clk);
        check(win_valid_o == 1'b0, "R1 win_valid in reset", {71'd0, win_valid_o}, 72'd0);
        rst = 1'b0;
        @(negedge clk);
        check(win_valid_o == 1'b0, "R1 win_valid after reset", {71'd0, win_valid_o}, 72'd0);

        // R7: continuous frame, frame start with first pixel (R8)
        phase = "R7 continuous frame";
        run_pixels(NPIX, 0, 1);

        // R9: pixels after the frame is complete are ignored
        phase = "R9 after frame";
        step(0, 0, 8'h00);
        step(0, 0, 8'h00);
        held = win_o;
        for (int k = 0; k < 20; k++) step(1, 0, 8'(k * 11 + 3));
        step(0, 0, 8'h00);
        check(win_o == held, "R9 taps unchanged", win_o, held);

        // R8: frame start alone, then a gapped partial frame (R2)
        phase = "R8/R2 gapped partial frame";
        step(0, 1, 8'h00);
        run_pixels(500, 2, 0);

        // R2: idle cycles keep the taps
        phase = "R2 idle hold";
        step(0, 0, 8'h00);
        held = win_o;
        repeat (5) step(0, 0, 8'($urandom));
        check(win_o == held, "R2 taps held on idle", win_o, held);

        // R8: restart mid-frame with a pixel, full gapped frame
        phase = "R8 mid-frame restart";
        run_pixels(NPIX, 1, 1);
        repeat (4) step(0, 0, 8'h00);

        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule